// File: doc/BRIEF.md
# Dual-Bank GPIO Controller with Edge Events

This block is a byte-addressed general-purpose I/O peripheral. Its pins are divided between two identical register banks, a core bank and a resume bank, placed a fixed 0x20 bytes apart. In each bank, every pin has its own bits for pin enable, direction, output level, rising-edge trigger, falling-edge trigger, event enable and trigger status. Software reaches eight pins with one byte access.

Pin inputs pass through a two-flop synchroniser. An edge detector compares the synchronised value with its value on the previous clock. An edge that matches an enabled trigger on an enabled pin sets a sticky status bit. Software clears that bit by writing one to it. Every status bit whose event enable is set feeds one level-sensitive event output, which stays high until software clears or masks all such bits in both banks.

The bus has no handshake: a write takes effect on the clock edge where the strobe is high, and read data is a combinational function of the address.

Top module: `dual_bank_gpio`

## Requirements
- R1: After reset, every register reads 0 except the direction register, which reads 1 for every implemented pin. `pinOe` and `evtOut` are 0.
- R2: Address map. Address bit 5 selects the bank: 0 selects the core bank and 1 (0x20) selects the resume bank. Address bits 4:2 select the register: enable 0x00, direction 0x04, level 0x08, rising trigger 0x0C, falling trigger 0x10, event enable 0x14, routing 0x18, status 0x1C. Address bits 1:0 select byte pin/8. Within that byte, a pin's bit is pin mod 8. A pin's index in its bank is its global index minus CORE_PINS for the resume bank. Writes to enable, direction, rising trigger, falling trigger and event enable read back unchanged.
- R3: A direction bit of 1 makes the pin an input and 0 makes it an output. `pinOe` is high exactly for pins that are enabled and set as outputs. `pinOut` carries the stored level bit.
- R4: A write to a level bit is ignored while the pin is an input. While the pin is an input, its level bit reads back the synchronised pin state. While it is an output, the level bit reads back the stored value.
- R5: The rising and falling triggers act independently. An enabled edge sets the pin's status bit no later than the third rising clock edge after the pin changes. An edge of the other polarity does not set it.
- R6: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged.
- R7: A pin whose enable bit is 0 never sets its status bit, whatever its trigger bits hold.
- R8: `evtOut` is high exactly while some status bit in either bank has its event-enable bit set.
- R9: Bits above a bank's implemented pin count read 0 and ignore writes. The routing register at 0x18 reads 0 in both banks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| busAddr | input | 6 | Byte address |
| busWdata | input | 8 | Write data |
| busWe | input | 1 | Write strobe, one cycle per write |
| busRdata | output | 8 | Read data for busAddr (combinational) |
| pinIn | input | CORE_PINS+RESUME_PINS | Pin input levels; core pins occupy the low bits |
| pinOut | output | CORE_PINS+RESUME_PINS | Output level driven on each pin |
| pinOe | output | CORE_PINS+RESUME_PINS | Output enable; 0 leaves the pin tri-stated |
| evtOut | output | 1 | Combined level-sensitive event |

## Verification
Most faults inside this block stay hidden until software reads the register concerned, so the bench reads back every register byte of both banks after each step. A wrong bit position or bank decode shows up as a mismatch on the next read. A status bit that was never set, or never cleared, shows on the status byte within three clocks of the pin edge. It also shows at once on `evtOut` when the pin is unmasked. A broken direction gate appears on `pinOe` and `pinOut` in the cycle after the write.

// File: rtl/gpio2b_pkg.sv
package gpio2b_pkg;

  typedef enum logic [2:0] {
    RG_EN    = 3'd0,
    RG_DIR   = 3'd1,
    RG_LVL   = 3'd2,
    RG_RISE  = 3'd3,
    RG_FALL  = 3'd4,
    RG_IE    = 3'd5,
    RG_ROUTE = 3'd6,
    RG_STS   = 3'd7
  } regSel_e;

  // Strobes handed from the bus decoder to both bank datapaths
  typedef struct packed {
    logic       wr;
    logic       bank;
    regSel_e    sel;
    logic [1:0] byteIdx;
    logic [7:0] data;
  } busStrobe_t;

endpackage

// File: rtl/gpio2b_ctrl.sv
module gpio2b_ctrl
  import gpio2b_pkg::*;
(
  input  logic [5:0]  busAddr,
  input  logic [7:0]  busWdata,
  input  logic        busWe,
  input  logic [7:0]  coreRd,
  input  logic [7:0]  resRd,
  input  logic        coreEvt,
  input  logic        resEvt,
  output busStrobe_t  strobe,
  output logic [7:0]  busRdata,
  output logic        evtOut
);

  always_comb begin
    strobe.wr      = busWe;
    strobe.bank    = busAddr[5];
    strobe.sel     = regSel_e'(busAddr[4:2]);
    strobe.byteIdx = busAddr[1:0];
    strobe.data    = busWdata;
  end

  assign busRdata = busAddr[5] ? resRd : coreRd;
  assign evtOut   = coreEvt | resEvt;

endmodule

// File: rtl/gpio2b_bank.sv
module gpio2b_bank
  import gpio2b_pkg::*;
#(
  parameter int PINS    = 10,
  parameter bit BANK_ID = 1'b0
) (
  input  logic            clk,
  input  logic            rst,
  input  busStrobe_t      strobe,
  input  logic [PINS-1:0] pinIn,
  output logic [PINS-1:0] pinOut,
  output logic [PINS-1:0] pinOe,
  output logic [7:0]      rdByte,
  output logic            evtAny,
  output logic [PINS-1:0] enBits,
  output logic [PINS-1:0] dirBits,
  output logic [PINS-1:0] stsBits
);

  localparam int ADDR_SPAN = 32;  // four bytes reachable per register

  logic [PINS-1:0] enR, dirR, lvlR, riseR, fallR, ieR, stsR;
  logic [PINS-1:0] syncA, syncB, syncPrev;
  logic [PINS-1:0] byteHit, wrBit, stsClr, newEdge, lvlView, rdVec;
  logic [ADDR_SPAN-1:0] padded;
  logic wrHere;

  assign wrHere = strobe.wr && (strobe.bank == BANK_ID);

  always_comb begin
    for (int p = 0; p < PINS; p++) begin
      byteHit[p] = wrHere && (strobe.byteIdx == 2'(p / 8));
      wrBit[p]   = strobe.data[p % 8];
      stsClr[p]  = byteHit[p] && (strobe.sel == RG_STS) && wrBit[p];
    end
  end

  // Control registers
  always_ff @(posedge clk) begin
    if (rst) begin
      enR   <= '0;
      dirR  <= '1;
      lvlR  <= '0;
      riseR <= '0;
      fallR <= '0;
      ieR   <= '0;
    end else begin
      for (int p = 0; p < PINS; p++) begin
        if (byteHit[p]) begin
          case (strobe.sel)
            RG_EN:   enR[p]   <= wrBit[p];
            RG_DIR:  dirR[p]  <= wrBit[p];
            RG_LVL:  if (!dirR[p]) lvlR[p] <= wrBit[p];
            RG_RISE: riseR[p] <= wrBit[p];
            RG_FALL: fallR[p] <= wrBit[p];
            RG_IE:   ieR[p]   <= wrBit[p];
            default: ;
          endcase
        end
      end
    end
  end

  // Input synchroniser plus one history stage for edge detection
  always_ff @(posedge clk) begin
    if (rst) begin
      syncA    <= '0;
      syncB    <= '0;
      syncPrev <= '0;
    end else begin
      syncA    <= pinIn;
      syncB    <= syncA;
      syncPrev <= syncB;
    end
  end

  assign newEdge = enR & ((syncB & ~syncPrev & riseR) | (~syncB & syncPrev & fallR));

  // Sticky status: a fresh edge wins over a clear in the same cycle
  always_ff @(posedge clk) begin
    if (rst) stsR <= '0;
    else     stsR <= (stsR & ~stsClr) | newEdge;
  end

  assign lvlView = (dirR & syncB) | (~dirR & lvlR);

  always_comb begin
    case (strobe.sel)
      RG_EN:   rdVec = enR;
      RG_DIR:  rdVec = dirR;
      RG_LVL:  rdVec = lvlView;
      RG_RISE: rdVec = riseR;
      RG_FALL: rdVec = fallR;
      RG_IE:   rdVec = ieR;
      RG_STS:  rdVec = stsR;
      default: rdVec = '0;
    endcase
    padded = '0;
    padded[PINS-1:0] = rdVec;
  end

  assign rdByte  = padded[{strobe.byteIdx, 3'b000} +: 8];
  assign pinOut  = lvlR;
  assign pinOe   = enR & ~dirR;
  assign evtAny  = |(stsR & ieR);
  assign enBits  = enR;
  assign dirBits = dirR;
  assign stsBits = stsR;

endmodule

// File: rtl/dual_bank_gpio.sv
module dual_bank_gpio
  import gpio2b_pkg::*;
#(
  parameter int CORE_PINS   = 10,
  parameter int RESUME_PINS = 4
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic [5:0]                       busAddr,
  input  logic [7:0]                       busWdata,
  input  logic                             busWe,
  output logic [7:0]                       busRdata,
  input  logic [CORE_PINS+RESUME_PINS-1:0] pinIn,
  output logic [CORE_PINS+RESUME_PINS-1:0] pinOut,
  output logic [CORE_PINS+RESUME_PINS-1:0] pinOe,
  output logic                             evtOut
);

  localparam int TOTAL = CORE_PINS + RESUME_PINS;

  busStrobe_t strobe;
  logic [7:0] coreRd, resRd;
  logic       coreEvt, resEvt;
  logic [TOTAL-1:0] allEn, allDir, allSts;

  gpio2b_ctrl u_ctrl (
    .busAddr (busAddr),
    .busWdata(busWdata),
    .busWe   (busWe),
    .coreRd  (coreRd),
    .resRd   (resRd),
    .coreEvt (coreEvt),
    .resEvt  (resEvt),
    .strobe  (strobe),
    .busRdata(busRdata),
    .evtOut  (evtOut)
  );

  gpio2b_bank #(.PINS(CORE_PINS), .BANK_ID(1'b0)) u_core (
    .clk    (clk),
    .rst    (rst),
    .strobe (strobe),
    .pinIn  (pinIn[CORE_PINS-1:0]),
    .pinOut (pinOut[CORE_PINS-1:0]),
    .pinOe  (pinOe[CORE_PINS-1:0]),
    .rdByte (coreRd),
    .evtAny (coreEvt),
    .enBits (allEn[CORE_PINS-1:0]),
    .dirBits(allDir[CORE_PINS-1:0]),
    .stsBits(allSts[CORE_PINS-1:0])
  );

  gpio2b_bank #(.PINS(RESUME_PINS), .BANK_ID(1'b1)) u_resume (
    .clk    (clk),
    .rst    (rst),
    .strobe (strobe),
    .pinIn  (pinIn[TOTAL-1:CORE_PINS]),
    .pinOut (pinOut[TOTAL-1:CORE_PINS]),
    .pinOe  (pinOe[TOTAL-1:CORE_PINS]),
    .rdByte (resRd),
    .evtAny (resEvt),
    .enBits (allEn[TOTAL-1:CORE_PINS]),
    .dirBits(allDir[TOTAL-1:CORE_PINS]),
    .stsBits(allSts[TOTAL-1:CORE_PINS])
  );

endmodule

// File: rtl/dual_bank_gpio_chk.sv
module dual_bank_gpio_chk #(
  parameter int TOTAL = 14
) (
  input logic             clk,
  input logic             rst,
  input logic             busWe,
  input logic             evtOut,
  input logic [TOTAL-1:0] pinOut,
  input logic [TOTAL-1:0] allEn,
  input logic [TOTAL-1:0] allDir,
  input logic [TOTAL-1:0] allSts
);

  AST_DISABLED_NO_STATUS: assert property (@(posedge clk) disable iff (rst)
    ((allSts & ~$past(allSts)) & ~$past(allEn)) == '0);  // R7

  AST_INPUT_LEVEL_FROZEN: assert property (@(posedge clk) disable iff (rst)
    ((pinOut ^ $past(pinOut)) & $past(allDir)) == '0);  // R4

  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (rst)
    (($past(allSts) & ~allSts) != '0) |-> $past(busWe));  // R6

  AST_EVENT_HELD: assert property (@(posedge clk) disable iff (rst)
    $fell(evtOut) |-> $past(busWe));  // R8

endmodule

bind dual_bank_gpio dual_bank_gpio_chk #(.TOTAL(TOTAL)) u_chk (
  .clk   (clk),
  .rst   (rst),
  .busWe (busWe),
  .evtOut(evtOut),
  .pinOut(pinOut),
  .allEn (allEn),
  .allDir(allDir),
  .allSts(allSts)
);

// File: tb/dual_bank_gpio_tb.sv
module dual_bank_gpio_tb;

  localparam int CP = 10;
  localparam int RP = 4;
  localparam int NT = CP + RP;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [5:0] busAddr = '0;
  logic [7:0] busWdata = '0;
  logic busWe = 1'b0;
  logic [7:0] busRdata;
  logic [NT-1:0] pinIn = '0;
  logic [NT-1:0] pinOut, pinOe;
  logic evtOut;

  int total = 0;
  int fails = 0;
  bit finished = 1'b0;

  logic [NT-1:0] mEn, mDir, mLvl, mRise, mFall, mIe, mSts, mPin;

  dual_bank_gpio #(.CORE_PINS(CP), .RESUME_PINS(RP)) u_dut (
    .clk(clk), .rst(rst), .busAddr(busAddr), .busWdata(busWdata), .busWe(busWe),
    .busRdata(busRdata), .pinIn(pinIn), .pinOut(pinOut), .pinOe(pinOe), .evtOut(evtOut)
  );

  always #10 clk = ~clk;  // 50 MHz

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int globalIdx(input bit bank, input int i);
    return bank ? CP + i : i;
  endfunction

  function automatic bit validLocal(input bit bank, input int i);
    return bank ? (i < RP) : (i < CP);
  endfunction

  function automatic logic [7:0] expByte(input logic [5:0] a);
    logic [7:0] r = '0;
    for (int k = 0; k < 8; k++) begin
      int i = a[1:0] * 8 + k;
      if (validLocal(a[5], i)) begin
        int g = globalIdx(a[5], i);
        case (a[4:2])
          3'd0: r[k] = mEn[g];
          3'd1: r[k] = mDir[g];
          3'd2: r[k] = mDir[g] ? mPin[g] : mLvl[g];
          3'd3: r[k] = mRise[g];
          3'd4: r[k] = mFall[g];
          3'd5: r[k] = mIe[g];
          3'd7: r[k] = mSts[g];
          default: r[k] = 1'b0;
        endcase
      end
    end
    return r;
  endfunction

  task automatic modelWrite(input logic [5:0] a, input logic [7:0] d);
    for (int k = 0; k < 8; k++) begin
      int i = a[1:0] * 8 + k;
      if (validLocal(a[5], i)) begin
        int g = globalIdx(a[5], i);
        case (a[4:2])
          3'd0: mEn[g] = d[k];
          3'd1: mDir[g] = d[k];
          3'd2: if (!mDir[g]) mLvl[g] = d[k];
          3'd3: mRise[g] = d[k];
          3'd4: mFall[g] = d[k];
          3'd5: mIe[g] = d[k];
          3'd7: if (d[k]) mSts[g] = 1'b0;
          default: ;
        endcase
      end
    end
  endtask

  task automatic busWrite(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0;
    modelWrite(a, d);
  endtask

  task automatic busRead(input logic [5:0] a, output logic [7:0] d);
    @(negedge clk);
    busAddr = a;
    #1 d = busRdata;
  endtask

  task automatic setPins(input logic [NT-1:0] nv);
    logic [NT-1:0] edges;
    @(negedge clk);
    edges = mEn & ((nv & ~mPin & mRise) | (~nv & mPin & mFall));
    pinIn = nv;
    repeat (4) @(negedge clk);
    mSts = mSts | edges;
    mPin = nv;
  endtask

  task automatic compareAll(input string tag);
    logic [7:0] d;
    for (int b = 0; b < 2; b++)
      for (int s = 0; s < 8; s++)
        for (int y = 0; y < 2; y++) begin
          logic [5:0] a = {b[0], s[2:0], y[1:0]};
          busRead(a, d);
          check(d == expByte(a), tag, d, expByte(a));
        end
    check(pinOe == (mEn & ~mDir), "R3 pinOe", pinOe, mEn & ~mDir);
    check(pinOut == mLvl, "R3 pinOut", pinOut, mLvl);
    check(evtOut == |(mSts & mIe), "R8 evtOut", evtOut, |(mSts & mIe));
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      total++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    void'($urandom(32'd4242));
    mEn = '0; mDir = '1; mLvl = '0; mRise = '0; mFall = '0; mIe = '0; mSts = '0; mPin = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    compareAll("R1 reset");
    check(pinOe == '0, "R1 pinOe", pinOe, 0);
    check(evtOut == 1'b0, "R1 evtOut", evtOut, 0);

    // R9: bits above pin count and the routing register
    busWrite(6'h20, 8'hFF); busRead(6'h20, d);
    check(d == 8'h0F, "R9 resume enable width", d, 8'h0F);
    busWrite(6'h01, 8'hFF); busRead(6'h01, d);
    check(d == 8'h03, "R9 core enable byte1", d, 8'h03);
    busWrite(6'h18, 8'hFF); busRead(6'h18, d);
    check(d == 8'h00, "R9 routing reads zero", d, 0);
    busWrite(6'h20, 8'h00); busWrite(6'h01, 8'h00);

    // R4: level write ignored while input
    busWrite(6'h00, 8'h01);
    setPins(14'h0001);
    busWrite(6'h08, 8'h00); busRead(6'h08, d);
    check(d[0] == 1'b1, "R4 input level shows pin", d[0], 1);
    busWrite(6'h04, 8'hFE); busRead(6'h08, d);
    check(d[0] == 1'b0, "R4 ignored write left level 0", d[0], 0);
    busWrite(6'h08, 8'h01); busRead(6'h08, d);
    check(d[0] == 1'b1, "R4 output level stored", d[0], 1);
    check(pinOut[0] == 1'b1 && pinOe[0] == 1'b1, "R3 pin0 driven high", {pinOe[0], pinOut[0]}, 3);
    compareAll("R2 map after R4 steps");

    // R5/R8: resume pins 10 rise-only, 11 fall-only
    busWrite(6'h20, 8'h0F); busWrite(6'h2C, 8'h01); busWrite(6'h30, 8'h02); busWrite(6'h34, 8'h03);
    setPins(14'h0401);
    busRead(6'h3C, d);
    check(d == 8'h01, "R5 rising edge sets status", d, 1);
    check(evtOut == 1'b1, "R8 event raised", evtOut, 1);
    setPins(14'h0C01); busRead(6'h3C, d);
    check(d == 8'h01, "R5 rise on fall-only pin ignored", d, 1);
    setPins(14'h0401); busRead(6'h3C, d);
    check(d == 8'h03, "R5 falling edge sets status", d, 3);

    // R6: write-one-to-clear
    busWrite(6'h3C, 8'h00); busRead(6'h3C, d);
    check(d == 8'h03, "R6 zero write keeps status", d, 3);
    busWrite(6'h3C, 8'h01); busRead(6'h3C, d);
    check(d == 8'h02, "R6 one clears bit", d, 2);
    check(evtOut == 1'b1, "R8 event held by other bit", evtOut, 1);
    busWrite(6'h3C, 8'h02);
    check(evtOut == 1'b0, "R8 event drops after clear", evtOut, 0);

    // R7: disabled pin ignores edges
    busWrite(6'h0C, 8'h20);
    setPins(14'h0421); busRead(6'h1C, d);
    check(d[5] == 1'b0, "R7 disabled pin no status", d[5], 0);
    compareAll("R2 map after directed");

    // Random mix of writes and pin activity
    for (int it = 0; it < 60; it++) begin
      logic [5:0] a = {1'($urandom), 3'($urandom), 1'b0, 1'($urandom)};
      busWrite(a, 8'($urandom));
      if ($urandom % 2) setPins(NT'($urandom));
      compareAll("R2 random");
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule